// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This unit performs 32-bit arithmetic that clamps instead of wrapping. It covers signed add, subtract and doubling with saturation, unsigned add and subtract with saturation, a wrapping add that still reports signed overflow, and clamping of a signed value into a chosen bit width. That clamping can target a signed or an unsigned range, and it works either on the whole word or on two independent 16-bit halves.

A 4-bit opcode selects the operation. When `valid_i` is high, the result is captured in an output register on the rising clock edge. Every clamp sets one shared sticky flag. Later operations never clear this flag. Only reset or the `clr_i` strobe clears it, and a clamp in the same cycle wins over the strobe. The surrounding datapath decodes instructions and issues one operation per valid cycle.

Top module: `sat_alu`

## Requirements
- R1: After reset `res_o` is 0 and `sticky_o` is 0.
- R2: Opcode 0 (signed add) and opcode 1 (signed subtract) return the exact result when it fits in 32 signed bits. When it does not fit, they return 0x7FFFFFFF if `a_i` is non-negative and 0x80000000 if `a_i` is negative, and they set the flag.
- R3: Opcode 2 (doubling of `a_i`) returns 0x7FFFFFFF and sets the flag for signed inputs ≥ 0x40000000. It returns 0x80000000 and sets the flag for signed inputs ≤ 0xC0000000; the value 0xC0000000 itself is included. Any other input returns `a_i` shifted left by one.
- R4: Opcode 3 (unsigned add) returns all ones and sets the flag on carry out. Opcode 4 (unsigned subtract) returns 0 and sets the flag when `b_i` > `a_i`. Otherwise both return the exact result.
- R5: Opcode 5 returns the wrapped 32-bit sum `a_i + b_i` and sets the flag on signed overflow.
- R6: Opcode 6 clamps signed `a_i` to width n = `width_i`. Let top be `a_i` arithmetically shifted right by n. If top > 0 the result is 2^n−1. If top < −1 the result is the bitwise inverse of 2^n−1. In both of these cases the flag is set. Otherwise the result is `a_i`.
- R7: Opcode 7 clamps signed `a_i` to the unsigned range 0..2^n−1, with n = `width_i`. A negative input gives 0 and sets the flag. An input above 2^n−1 gives 2^n−1 and sets the flag.
- R8: Opcodes 8 (signed) and 9 (unsigned) apply the R6 and R7 rules separately to the sign-extended halves `a_i[31:16]` and `a_i[15:0]`. They use only `width_i[3:0]` as n, so bit 4 is ignored. The two 16-bit results are packed into the same halves of the output. A clamp in either half sets the flag.
- R9: The flag rises on the same edge that registers a clamped result. An operation that does not clamp never clears it. `clr_i` clears it on the next edge, unless a valid operation in that same cycle clamps.
- R10: While `valid_i` is low, `res_o` and the flag keep their values whatever the operand and opcode inputs are; only `clr_i` still acts.
- R11: Opcodes 10 to 15 return 0 and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand / value to clamp |
| b_i | input | 32 | Second operand |
| width_i | input | 5 | Clamp width n |
| clr_i | input | 1 | Sticky flag clear strobe |
| res_o | output | 32 | Registered result |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is a clear and a clamp landing in the same cycle. The bench drives `clr_i` together with an overflowing unsigned add and expects the flag to stay set. The single-lane clamp in the 16-bit forms is also hard to separate: a clamp in only one half must still set the shared flag. The bench covers this with operands where only the low half exceeds the range. It also sets `width_i` bit 4 in that test to show that this bit is ignored. The doubling boundary at 0xC0000000 is driven on its own, because there the flag rises even though the result is exact.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_SDBL   = 4'd2,
    OP_UADD   = 4'd3,
    OP_USUB   = 4'd4,
    OP_WADD   = 4'd5,
    OP_SCLP   = 4'd6,
    OP_UCLP   = 4'd7,
    OP_SCLP16 = 4'd8,
    OP_UCLP16 = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] sh_i,
  input  logic          uns_i,
  output logic [W-1:0]  res_o,
  output logic          hit_o
);
  localparam logic signed [W-1:0] S_ZERO = '0;
  localparam logic signed [W-1:0] S_M1   = '1;

  logic signed [W-1:0] top;
  logic [W-1:0]        mask;

  assign top  = $signed(val_i) >>> sh_i;
  assign mask = (W'(1) << sh_i) - W'(1);

  always_comb begin
    res_o = val_i;
    hit_o = 1'b0;
    if (uns_i) begin
      if (val_i[W-1]) begin
        res_o = '0;
        hit_o = 1'b1;
      end else if (val_i > mask) begin
        res_o = mask;
        hit_o = 1'b1;
      end
    end else begin
      if (top > S_ZERO) begin
        res_o = mask;
        hit_o = 1'b1;
      end else if (top < S_M1) begin
        res_o = ~mask;
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_arith.sv
module sat_arith
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  sat_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         hit_o
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   sum_x, dif_x;
  logic [W-1:0] sum, dif, s_clamp;
  logic         add_ovf, sub_ovf, dbl_hi, dbl_lo;

  assign sum_x   = {1'b0, a_i} + {1'b0, b_i};
  assign dif_x   = {1'b0, a_i} - {1'b0, b_i};
  assign sum     = sum_x[W-1:0];
  assign dif     = dif_x[W-1:0];
  assign add_ovf = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
  assign sub_ovf = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);
  assign s_clamp = a_i[W-1] ? S_MIN : S_MAX;
  // boundary value 0xC0.. counts as a clamp
  assign dbl_hi  = !a_i[W-1] && a_i[W-2];
  assign dbl_lo  = a_i[W-1] && (!a_i[W-2] || (a_i[W-3:0] == '0));

  always_comb begin
    res_o = '0;
    hit_o = 1'b0;
    unique case (op_i)
      OP_SADD: begin
        res_o = add_ovf ? s_clamp : sum;
        hit_o = add_ovf;
      end
      OP_SSUB: begin
        res_o = sub_ovf ? s_clamp : dif;
        hit_o = sub_ovf;
      end
      OP_SDBL: begin
        if (dbl_hi)      res_o = S_MAX;
        else if (dbl_lo) res_o = S_MIN;
        else             res_o = {a_i[W-2:0], 1'b0};
        hit_o = dbl_hi || dbl_lo;
      end
      OP_UADD: begin
        res_o = sum_x[W] ? '1 : sum;
        hit_o = sum_x[W];
      end
      OP_USUB: begin
        res_o = dif_x[W] ? '0 : dif;
        hit_o = dif_x[W];
      end
      OP_WADD: begin
        res_o = sum;
        hit_o = add_ovf;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [3:0]                op_i,
  input  logic [DATA_W-1:0]         a_i,
  input  logic [DATA_W-1:0]         b_i,
  input  logic [$clog2(DATA_W)-1:0] width_i,
  input  logic                      clr_i,
  output logic [DATA_W-1:0]         res_o,
  output logic                      sticky_o
);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int LANE_W = DATA_W / 2;
  localparam int LSH_W  = $clog2(LANE_W);
  localparam int NLANE  = 2;

  sat_op_e op;
  assign op = sat_op_e'(op_i);

  logic [DATA_W-1:0] ar_res, cl_res, lane_res, nxt_res;
  logic              ar_hit, cl_hit, nxt_hit;
  logic [NLANE-1:0]  lane_hit;

  sat_arith #(.W(DATA_W)) u_arith (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(ar_res),
    .hit_o(ar_hit)
  );

  sat_clamp #(.W(DATA_W), .SW(SH_W)) u_clamp (
    .val_i(a_i),
    .sh_i (width_i),
    .uns_i(op == OP_UCLP),
    .res_o(cl_res),
    .hit_o(cl_hit)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    sat_clamp #(.W(LANE_W), .SW(LSH_W)) u_lane (
      .val_i(a_i[g*LANE_W +: LANE_W]),
      .sh_i (width_i[LSH_W-1:0]),
      .uns_i(op == OP_UCLP16),
      .res_o(lane_res[g*LANE_W +: LANE_W]),
      .hit_o(lane_hit[g])
    );
  end

  always_comb begin
    nxt_res = '0;
    nxt_hit = 1'b0;
    case (op)
      OP_SADD, OP_SSUB, OP_SDBL, OP_UADD, OP_USUB, OP_WADD: begin
        nxt_res = ar_res;
        nxt_hit = ar_hit;
      end
      OP_SCLP, OP_UCLP: begin
        nxt_res = cl_res;
        nxt_hit = cl_hit;
      end
      OP_SCLP16, OP_UCLP16: begin
        nxt_res = lane_res;
        nxt_hit = |lane_hit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      sticky_o <= 1'b0;
    end else begin
      if (valid_i) res_o <= nxt_res;
      if (valid_i && nxt_hit) sticky_o <= 1'b1;
      else if (clr_i)         sticky_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      valid_i,
  input logic [3:0]                op_i,
  input logic [DATA_W-1:0]         a_i,
  input logic [DATA_W-1:0]         b_i,
  input logic                      clr_i,
  input logic [DATA_W-1:0]         res_o,
  input logic                      sticky_o
);
  logic [DATA_W:0] usum;
  assign usum = {1'b0, a_i} + {1'b0, b_i};

  // R9
  sticky_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sticky_o) |-> $past(clr_i));

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd3 && usum[DATA_W] && clr_i) |=> sticky_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> ($stable(res_o) && $stable(sticky_o)));

  // R4
  uadd_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd3) |=> (res_o >= $past(a_i)));

  // R4
  usub_ceil_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd4) |=> (res_o <= $past(a_i)));

  // R7
  usat_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd7) |=> !res_o[DATA_W-1]);

  // R11
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd9) |=> (res_o == '0));
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .clr_i   (clr_i),
  .res_o   (res_o),
  .sticky_o(sticky_o)
);

// File: tb/tb_sat_alu.sv
module tb_sat_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  width_i = '0;
  logic        clr_i = 1'b0;
  logic [31:0] res_o;
  logic        sticky_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sat_alu dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .width_i, .clr_i, .res_o, .sticky_o
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] w);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; width_i = w; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // clear flag, run one op, check result and flag
  task automatic one(input string tag, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] w,
                     input logic [31:0] exp_res, input logic exp_flag);
    clear_flag();
    issue(op, a, b, w);
    check({tag, " res"}, res_o, exp_res);
    check({tag, " flag"}, {31'd0, sticky_o}, {31'd0, exp_flag});
  endtask

  task automatic t_reset();
    check("R1 res", res_o, 32'h0);
    check("R1 flag", {31'd0, sticky_o}, 32'h0);
  endtask

  task automatic t_signed();
    one("R2 add pos ovf", 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h7FFFFFFF, 1'b1);
    one("R2 add neg ovf", 4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1);
    one("R2 add fit", 4'd0, 32'h5, 32'hFFFFFFFD, 5'd0, 32'h2, 1'b0);
    one("R2 sub neg ovf", 4'd1, 32'h80000000, 32'h1, 5'd0, 32'h80000000, 1'b1);
    one("R2 sub pos ovf", 4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
    one("R2 sub fit", 4'd1, 32'd10, 32'd3, 5'd0, 32'd7, 1'b0);
  endtask

  task automatic t_double();
    one("R3 dbl hi edge", 4'd2, 32'h40000000, 32'h0, 5'd0, 32'h7FFFFFFF, 1'b1);
    one("R3 dbl hi fit", 4'd2, 32'h3FFFFFFF, 32'h0, 5'd0, 32'h7FFFFFFE, 1'b0);
    one("R3 dbl lo edge", 4'd2, 32'hC0000000, 32'h0, 5'd0, 32'h80000000, 1'b1);
    one("R3 dbl lo fit", 4'd2, 32'hC0000001, 32'h0, 5'd0, 32'h80000002, 1'b0);
  endtask

  task automatic t_unsigned();
    one("R4 uadd carry", 4'd3, 32'hFFFFFFF0, 32'h20, 5'd0, 32'hFFFFFFFF, 1'b1);
    one("R4 uadd fit", 4'd3, 32'd1, 32'd2, 5'd0, 32'd3, 1'b0);
    one("R4 usub borrow", 4'd4, 32'd3, 32'd5, 5'd0, 32'd0, 1'b1);
    one("R4 usub fit", 4'd4, 32'd5, 32'd3, 5'd0, 32'd2, 1'b0);
  endtask

  task automatic t_wadd();
    one("R5 wrap ovf", 4'd5, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h80000000, 1'b1);
    one("R5 wrap fit", 4'd5, 32'h10, 32'h20, 5'd0, 32'h30, 1'b0);
  endtask

  task automatic t_sclamp();
    one("R6 hi", 4'd6, 32'd200, 32'h0, 5'd7, 32'd127, 1'b1);
    one("R6 lo", 4'd6, -32'sd300, 32'h0, 5'd7, 32'hFFFFFF80, 1'b1);
    one("R6 fit", 4'd6, 32'd100, 32'h0, 5'd7, 32'd100, 1'b0);
    one("R6 min fit", 4'd6, -32'sd128, 32'h0, 5'd7, 32'hFFFFFF80, 1'b0);
    one("R6 n0", 4'd6, 32'd1, 32'h0, 5'd0, 32'd0, 1'b1);
  endtask

  task automatic t_uclamp();
    one("R7 neg", 4'd7, -32'sd5, 32'h0, 5'd8, 32'd0, 1'b1);
    one("R7 hi", 4'd7, 32'd300, 32'h0, 5'd8, 32'd255, 1'b1);
    one("R7 fit", 4'd7, 32'd200, 32'h0, 5'd8, 32'd200, 1'b0);
    one("R7 n31", 4'd7, 32'h7FFFFFFF, 32'h0, 5'd31, 32'h7FFFFFFF, 1'b0);
  endtask

  task automatic t_lanes();
    one("R8 s both", 4'd8, 32'h0100FF00, 32'h0, 5'd7, 32'h007FFF80, 1'b1);
    one("R8 s fit", 4'd8, 32'h0005FFFB, 32'h0, 5'd7, 32'h0005FFFB, 1'b0);
    one("R8 s low only w bit4", 4'd8, 32'h00000200, 32'h0, 5'h17, 32'h0000007F, 1'b1);
    one("R8 u both", 4'd9, 32'h80000123, 32'h0, 5'd8, 32'h000000FF, 1'b1);
    one("R8 u fit", 4'd9, 32'h00100020, 32'h0, 5'd8, 32'h00100020, 1'b0);
  endtask

  task automatic t_sticky();
    clear_flag();
    issue(4'd3, 32'hFFFFFFFF, 32'h1, 5'd0);
    check("R9 set", {31'd0, sticky_o}, 32'd1);
    issue(4'd3, 32'd1, 32'd1, 5'd0);
    check("R9 kept by plain op", {31'd0, sticky_o}, 32'd1);
    check("R9 plain op res", res_o, 32'd2);
    clear_flag();
    check("R9 cleared", {31'd0, sticky_o}, 32'd0);
    @(negedge clk_i);
    op_i = 4'd3; a_i = 32'hFFFFFFFF; b_i = 32'h2; valid_i = 1'b1; clr_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; clr_i = 1'b0;
    check("R9 set beats clear", {31'd0, sticky_o}, 32'd1);
  endtask

  task automatic t_hold();
    one("R10 setup", 4'd1, 32'd9, 32'd4, 5'd0, 32'd5, 1'b0);
    @(negedge clk_i);
    op_i = 4'd0; a_i = 32'h7FFFFFFF; b_i = 32'h7FFFFFFF;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10 res held", res_o, 32'd5);
    check("R10 flag held", {31'd0, sticky_o}, 32'd0);
  endtask

  task automatic t_reserved();
    one("R11 op15", 4'd15, 32'h12345678, 32'h1, 5'd3, 32'h0, 1'b0);
    clear_flag();
    issue(4'd4, 32'd0, 32'd1, 5'd0);
    issue(4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0);
    check("R11 op10 res", res_o, 32'h0);
    check("R11 flag untouched", {31'd0, sticky_o}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_signed();
    t_double();
    t_unsigned();
    t_wadd();
    t_sclamp();
    t_uclamp();
    t_lanes();
    t_sticky();
    t_hold();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule